// File: doc/BRIEF.md
# Serial Wire Debug Transfer Engine

This block is the host side of one serial wire debug register access. It runs the two-wire link: a clock line that it always drives, and a data line that it drives, releases and takes back as the transfer proceeds. Given a 4-bit request and, for a write, a 32-bit word, it sends the request header and hands the line over to the target. It then reads the target's 3-bit response and runs the closing sequence that this response calls for. When the transfer is over it reports the response, any read data and a read-parity flag in a single-cycle done pulse.

The bit rate comes from a strobe input. Each strobe ends one half of a link clock period. The turnaround length, the number of trailing idle clocks and the option to run a dummy data phase after a WAIT or FAULT response are set per transfer. They are captured together with the request. Between transfers the clock line rests high and the data line is driven high. A new request is taken only while the engine is idle.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is 8 bits in this order: a 1, request bits 0 through 3, an even parity bit over those four bits (parity = XOR of the four), a 0, then a 1. Request bit 1 set means a read.
- R2: Out of reset and between transfers, `swclk`=1, `swdio_oe`=1, `swdio_o`=1 and `busy`=0. A `start` pulse is taken only while `busy`=0. At that moment the request, write word and configuration are captured, and later changes to those inputs have no effect on the transfer in progress.
- R3: `swclk` changes only on a cycle after `tick` was high. Each link bit is one low half followed by one high half. Driven data changes only as `swclk` falls, and input data is captured at the strobe that raises `swclk`.
- R4: After the header the line is released (`swdio_oe`=0) for `cfg_turn`+1 clocks. Three response bits are then sampled least significant first. OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R5: On OK to a read, 32 data bits are sampled least significant first and then a parity bit. `perr` is 1 when that bit differs from the XOR of the data. Then `cfg_turn`+1 released clocks follow.
- R6: On OK to a write, `cfg_turn`+1 released clocks come first. The engine then drives 32 data bits least significant first and their even parity bit.
- R7: After an OK transfer the engine drives 0 for `cfg_idle` clocks (none when zero). It then sets the data line to 1 with `swdio_oe`=1 without a further clock, leaving `swclk` high.
- R8: On WAIT or FAULT: if the data-phase option is set and the request is a read, the engine runs 33 released clocks, then `cfg_turn`+1 released clocks, then 33 clocks driving 0. Otherwise it runs only the `cfg_turn`+1 released clocks. It ends driving 1.
- R9: Any other response value runs `cfg_turn`+34 released clocks, then drives 1 and reports the raw response.
- R10: `done` is high for exactly one cycle per transfer. In that cycle it presents the raw 3-bit response on `ack` and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-period strobe setting the link bit rate |
| start | input | 1 | Begin a transfer (taken only when idle) |
| req | input | 4 | Request bits; bit 1 selects read |
| wdata | input | 32 | Word to write |
| cfg_turn | input | 2 | Turnaround clocks minus one |
| cfg_idle | input | 8 | Trailing idle clocks after an OK transfer |
| cfg_data_phase | input | 1 | Run the dummy data phase after WAIT/FAULT on reads |
| swdio_i | input | 1 | Data line as seen at the pad |
| swclk | output | 1 | Link clock |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 3 | Raw response of the last transfer |
| rdata | output | 32 | Word read by the last OK read |
| perr | output | 1 | Read parity mismatch |

## Verification
The embedded properties watch the timing rules on every cycle. They check that the clock line moves only after a strobe, that driven data changes only with a falling clock, and that the line is released only inside a transfer. They also check that the engine rests with the clock high, and that the done pulse lasts one cycle with the line driven high. The bench's scenarios are needed to show the content of each transfer. That content is the exact header bits and parity, the number of turnaround, data, dummy and idle clocks on each response path, the read word with a good or a corrupted parity bit, and that a start arriving mid-transfer is ignored.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

    typedef enum logic [3:0] {
        PH_IDLE     = 4'd0,
        PH_HDR      = 4'd1,
        PH_TRN_ACK  = 4'd2,
        PH_ACK      = 4'd3,
        PH_RD       = 4'd4,
        PH_TRN_RD   = 4'd5,
        PH_TRN_WR   = 4'd6,
        PH_WR       = 4'd7,
        PH_IDLE_CYC = 4'd8,
        PH_WF_SKIP  = 4'd9,
        PH_WF_TRN   = 4'd10,
        PH_WF_FILL  = 4'd11,
        PH_ERR      = 4'd12,
        PH_FIN      = 4'd13
    } swd_phase_e;

    localparam logic [2:0] RSP_OK    = 3'b001;
    localparam logic [2:0] RSP_WAIT  = 3'b010;
    localparam logic [2:0] RSP_FAULT = 3'b100;

    localparam int REQ_W   = 4;
    localparam int RNW_BIT = 1;
    localparam int HDR_LEN = 8;

endpackage

// File: rtl/swd_parity.sv
module swd_parity #(
    parameter int W = 4
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ bits[i];
    end
    assign odd = chain[W];
endmodule

// File: rtl/swd_half_clock.sv
module swd_half_clock (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic line,
    output logic fall_ev,
    output logic rise_ev
);
    logic line_d, line_q;

    assign fall_ev = tick & run & line_q;
    assign rise_ev = tick & ~line_q;
    assign line    = line_q;

    always_comb begin
        line_d = line_q;
        if (fall_ev) begin
            line_d = 1'b0;
        end else if (rise_ev) begin
            line_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_d;
        end
    end

    AST_CLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_q) |-> $past(tick)); // R3

endmodule

// File: rtl/swd_seq_fsm.sv
module swd_seq_fsm
    import swd_xfer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TRN_W  = 2,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              start,
    input  logic [REQ_W-1:0]  req,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  cfg_turn,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic              cfg_dp,
    input  logic              din,
    input  logic              hdr_par,
    input  logic              wr_par,
    input  logic              rd_par,
    output logic              run,
    output logic              busy,
    output logic              dout,
    output logic              oe,
    output logic              done,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              perr,
    output logic [REQ_W-1:0]  req_lat,
    output logic [DATA_W-1:0] wdata_lat
);
    localparam int ERR_MAX = DATA_W + (1 << TRN_W);
    localparam int CNT_A   = $clog2(ERR_MAX + 1);
    localparam int CNT_W   = (IDLE_W > CNT_A) ? IDLE_W : CNT_A;
    localparam int IDX_W   = $clog2(DATA_W);

    typedef struct packed {
        swd_phase_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [REQ_W-1:0]    req;
        logic [DATA_W-1:0]   wdata;
        logic [TRN_W:0]      trn;
        logic [IDLE_W-1:0]   idle;
        logic                dp;
        logic [2:0]          ack;
        logic [DATA_W-1:0]   rdata;
        logic                perr;
        logic                dout;
        logic                oe;
        logic                done;
    } seq_state_t;

    seq_state_t q, n;

    logic [CNT_W-1:0] last;
    logic [2:0]       ack_full;
    logic             wf_dummy;
    logic             drv_en;
    logic             drv_bit;
    swd_phase_e       after_ok;
    swd_phase_e       nxt;

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        ack_full = {din, q.ack[1:0]};
        wf_dummy = q.dp & q.req[RNW_BIT];
        after_ok = (q.idle != '0) ? PH_IDLE_CYC : PH_FIN;

        // final bit index of the current phase
        case (q.st)
            PH_HDR:                                      last = CNT_W'(HDR_LEN - 1);
            PH_TRN_ACK, PH_TRN_RD, PH_TRN_WR, PH_WF_TRN: last = CNT_W'(q.trn) - CNT_W'(1);
            PH_ACK:                                      last = CNT_W'(2);
            PH_RD, PH_WR, PH_WF_SKIP, PH_WF_FILL:        last = CNT_W'(DATA_W);
            PH_IDLE_CYC:                                 last = CNT_W'(q.idle) - CNT_W'(1);
            PH_ERR:                                      last = CNT_W'(q.trn) + CNT_W'(DATA_W);
            default:                                     last = '0;
        endcase

        // value and enable for a driven bit
        drv_en  = 1'b0;
        drv_bit = 1'b1;
        case (q.st)
            PH_HDR: begin
                drv_en = 1'b1;
                case (q.cnt[2:0])
                    3'd0:    drv_bit = 1'b1;
                    3'd1:    drv_bit = q.req[0];
                    3'd2:    drv_bit = q.req[1];
                    3'd3:    drv_bit = q.req[2];
                    3'd4:    drv_bit = q.req[3];
                    3'd5:    drv_bit = hdr_par;
                    3'd6:    drv_bit = 1'b0;
                    default: drv_bit = 1'b1;
                endcase
            end
            PH_WR: begin
                drv_en  = 1'b1;
                drv_bit = (q.cnt < CNT_W'(DATA_W)) ? q.wdata[q.cnt[IDX_W-1:0]] : wr_par;
            end
            PH_IDLE_CYC, PH_WF_FILL: begin
                drv_en  = 1'b1;
                drv_bit = 1'b0;
            end
            default: begin
                drv_en  = 1'b0;
                drv_bit = 1'b1;
            end
        endcase

        // phase that follows the last bit
        case (q.st)
            PH_HDR:     nxt = PH_TRN_ACK;
            PH_TRN_ACK: nxt = PH_ACK;
            PH_ACK: begin
                case (ack_full)
                    RSP_OK:              nxt = q.req[RNW_BIT] ? PH_RD : PH_TRN_WR;
                    RSP_WAIT, RSP_FAULT: nxt = wf_dummy ? PH_WF_SKIP : PH_WF_TRN;
                    default:             nxt = PH_ERR;
                endcase
            end
            PH_RD:      nxt = PH_TRN_RD;
            PH_TRN_RD:  nxt = after_ok;
            PH_TRN_WR:  nxt = PH_WR;
            PH_WR:      nxt = after_ok;
            PH_WF_SKIP: nxt = PH_WF_TRN;
            PH_WF_TRN:  nxt = wf_dummy ? PH_WF_FILL : PH_FIN;
            default:    nxt = PH_FIN;
        endcase

        case (q.st)
            PH_IDLE: begin
                if (start) begin
                    n.st    = PH_HDR;
                    n.cnt   = '0;
                    n.req   = req;
                    n.wdata = wdata;
                    n.trn   = {1'b0, cfg_turn} + {{TRN_W{1'b0}}, 1'b1};
                    n.idle  = cfg_idle;
                    n.dp    = cfg_dp;
                    n.ack   = '0;
                    n.perr  = 1'b0;
                end
            end
            PH_FIN: begin
                if (tick) begin
                    n.dout = 1'b1;
                    n.oe   = 1'b1;
                    n.done = 1'b1;
                    n.st   = PH_IDLE;
                end
            end
            default: begin
                if (fall_ev) begin
                    n.oe   = drv_en;
                    n.dout = drv_bit;
                end
                if (rise_ev) begin
                    if (q.st == PH_ACK) begin
                        n.ack[q.cnt[1:0]] = din;
                    end
                    if (q.st == PH_RD) begin
                        if (q.cnt < CNT_W'(DATA_W)) begin
                            n.rdata[q.cnt[IDX_W-1:0]] = din;
                        end else begin
                            n.perr = din ^ rd_par;
                        end
                    end
                    if (q.cnt == last) begin
                        n.cnt = '0;
                        n.st  = nxt;
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.dout <= 1'b1;
            q.oe   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != PH_IDLE);
    assign run       = busy && (q.st != PH_FIN);
    assign dout      = q.dout;
    assign oe        = q.oe;
    assign done      = q.done;
    assign ack       = q.ack;
    assign rdata     = q.rdata;
    assign perr      = q.perr;
    assign req_lat   = q.req;
    assign wdata_lat = q.wdata;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R10
    AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.oe && q.dout)); // R7
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.dout) && !q.done) |-> $past(fall_ev)); // R3
    AST_RELEASE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe |-> busy); // R4

endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine #(
    parameter int DATA_W = 32,
    parameter int TRN_W  = 2,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [3:0]        req,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  cfg_turn,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic              cfg_data_phase,
    input  logic              swdio_i,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic              busy,
    output logic              done,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              perr
);
    logic              run, fall_ev, rise_ev;
    logic              hdr_par, wr_par, rd_par;
    logic [3:0]        req_lat;
    logic [DATA_W-1:0] wdata_lat;

    swd_half_clock u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .line    (swclk),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    swd_parity #(.W(4))      u_hdr_par (.bits(req_lat),   .odd(hdr_par));
    swd_parity #(.W(DATA_W)) u_wr_par  (.bits(wdata_lat), .odd(wr_par));
    swd_parity #(.W(DATA_W)) u_rd_par  (.bits(rdata),     .odd(rd_par));

    swd_seq_fsm #(
        .DATA_W (DATA_W),
        .TRN_W  (TRN_W),
        .IDLE_W (IDLE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .start     (start),
        .req       (req),
        .wdata     (wdata),
        .cfg_turn  (cfg_turn),
        .cfg_idle  (cfg_idle),
        .cfg_dp    (cfg_data_phase),
        .din       (swdio_i),
        .hdr_par   (hdr_par),
        .wr_par    (wr_par),
        .rd_par    (rd_par),
        .run       (run),
        .busy      (busy),
        .dout      (swdio_o),
        .oe        (swdio_oe),
        .done      (done),
        .ack       (ack),
        .rdata     (rdata),
        .perr      (perr),
        .req_lat   (req_lat),
        .wdata_lat (wdata_lat)
    );

    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && swdio_oe && swdio_o)); // R2

endmodule

// File: tb/swd_xfer_engine_tb.sv
module swd_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  req = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  cfg_turn = '0;
    logic [7:0]  cfg_idle = '0;
    logic        cfg_dp = 1'b0;
    logic        swdio_i = 1'b1;
    logic        swclk, swdio_o, swdio_oe, busy, done, perr;
    logic [2:0]  ack;
    logic [31:0] rdata;

    always #2 clk = ~clk;

    swd_xfer_engine u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .start          (start),
        .req            (req),
        .wdata          (wdata),
        .cfg_turn       (cfg_turn),
        .cfg_idle       (cfg_idle),
        .cfg_data_phase (cfg_dp),
        .swdio_i        (swdio_i),
        .swclk          (swclk),
        .swdio_o        (swdio_o),
        .swdio_oe       (swdio_oe),
        .busy           (busy),
        .done           (done),
        .ack            (ack),
        .rdata          (rdata),
        .perr           (perr)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // expected line activity, one entry per rising link clock
    bit e_oe [512];
    bit e_v  [512];
    bit e_rsp[512];
    int ne = 0;
    int idx = 0;
    int mism = 0;
    int hdr_mism = 0;
    int bad_clk = 0;
    int seen = 0;
    int tdiv = 2;

    typedef struct {
        logic [2:0]  ack;
        logic [31:0] rdata;
        bit          chk_rd;
        bit          perr;
        int          nedge;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic put(input bit o, input bit v, input bit r);
        e_oe[ne]  = o;
        e_v[ne]   = v;
        e_rsp[ne] = r;
        ne++;
    endtask

    // target model: answers on the falling edge, observes on the rising edge
    always @(posedge swclk) begin
        if (rst_n) begin
            if (idx < ne) begin
                if (swdio_oe != e_oe[idx] || (e_oe[idx] && swdio_o != e_v[idx])) begin
                    mism++;
                    if (idx < 8) hdr_mism++;
                end
            end else begin
                mism++;
            end
            idx++;
        end
    end

    always @(negedge swclk) begin
        swdio_i = (idx < ne) ? e_rsp[idx] : 1'b1;
    end

    // strobe generator
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            tick = ((c % tdiv) == 0);
        end
    end

    // link clock may only move after a strobe (R3)
    logic tick_seen = 1'b0;
    logic sw_prev = 1'b1;
    always @(posedge clk) tick_seen <= tick;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && swclk !== sw_prev && !tick_seen) bad_clk++;
            sw_prev = swclk;
        end
    end

    // monitor: pops one expected result per done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected completion", 32'd1, 32'd0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(ack == it.ack, it.tag, "response", {29'd0, ack}, {29'd0, it.ack});
                    check(perr == it.perr, "R5", "parity flag", {31'd0, perr}, {31'd0, it.perr});
                    if (it.chk_rd)
                        check(rdata == it.rdata, "R5", "read word", rdata, it.rdata);
                    check(idx == it.nedge, it.tag, "clock count", idx, it.nedge);
                    check(hdr_mism == 0, "R1", "header bits", hdr_mism, 0);
                    check(mism == 0, it.tag, "line pattern", mism, 0);
                    check(swclk && swdio_oe && swdio_o, "R7", "parked line",
                          {29'd0, swclk, swdio_oe, swdio_o}, 32'd7);
                end
                @(negedge clk);
                check(!done && !busy, "R10", "single done pulse", {30'd0, done, busy}, 32'd0);
                seen++;
            end
        end
    end

    task automatic run_txn(input logic [3:0] rq, input logic [31:0] wd,
                           input logic [1:0] tn, input logic [7:0] idl, input bit dp,
                           input logic [2:0] a, input logic [31:0] rd, input bit badp,
                           input string tag, input bit poke);
        exp_t it;
        int   t;
        int   target;
        bit   rnw;
        t   = int'(tn) + 1;
        rnw = rq[1];
        ne  = 0;
        put(1, 1, 1);
        for (int i = 0; i < 4; i++) put(1, rq[i], 1);
        put(1, ^rq, 1);
        put(1, 0, 1);
        put(1, 1, 1);
        for (int i = 0; i < t; i++) put(0, 0, 1);
        for (int i = 0; i < 3; i++) put(0, 0, a[i]);
        it.chk_rd = 1'b0;
        it.perr   = 1'b0;
        it.rdata  = '0;
        if (a == 3'b001) begin
            if (rnw) begin
                for (int i = 0; i < 32; i++) put(0, 0, rd[i]);
                put(0, 0, (^rd) ^ badp);
                for (int i = 0; i < t; i++) put(0, 0, 1);
                it.chk_rd = 1'b1;
                it.rdata  = rd;
                it.perr   = badp;
            end else begin
                for (int i = 0; i < t; i++) put(0, 0, 1);
                for (int i = 0; i < 32; i++) put(1, wd[i], 1);
                put(1, ^wd, 1);
            end
            for (int i = 0; i < int'(idl); i++) put(1, 0, 1);
        end else if (a == 3'b010 || a == 3'b100) begin
            if (dp && rnw) for (int i = 0; i < 33; i++) put(0, 0, 1);
            for (int i = 0; i < t; i++) put(0, 0, 1);
            if (dp && rnw) for (int i = 0; i < 33; i++) put(1, 0, 1);
        end else begin
            for (int i = 0; i < t + 33; i++) put(0, 0, 1);
        end
        it.ack   = a;
        it.nedge = ne;
        it.tag   = tag;
        sb_q.push_back(it);
        idx      = 0;
        mism     = 0;
        hdr_mism = 0;
        target   = seen + 1;
        @(negedge clk);
        req      = rq;
        wdata    = wd;
        cfg_turn = tn;
        cfg_idle = idl;
        cfg_dp   = dp;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        // captured at start: scramble the inputs (R2)
        req      = ~rq;
        wdata    = ~wd;
        cfg_turn = ~tn;
        cfg_idle = ~idl;
        cfg_dp   = ~dp;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (seen < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(swclk == 1'b1, "R2", "reset clock level", {31'd0, swclk}, 32'd1);
        check(swdio_oe == 1'b1, "R2", "reset enable", {31'd0, swdio_oe}, 32'd1);
        check(swdio_o == 1'b1, "R2", "reset data", {31'd0, swdio_o}, 32'd1);
        check(!busy && !done, "R2", "reset idle", {30'd0, busy, done}, 32'd0);

        run_txn(4'b0010, 32'h0, 2'd0, 8'd0, 1'b0, 3'b001, 32'hDEAD_BEEF, 1'b0, "R5", 1'b0);
        run_txn(4'b1011, 32'h0, 2'd1, 8'd3, 1'b0, 3'b001, 32'h0000_0001, 1'b1, "R7", 1'b0);
        run_txn(4'b1101, 32'h1234_5678, 2'd3, 8'd8, 1'b0, 3'b001, 32'h0, 1'b0, "R6", 1'b0);
        run_txn(4'b0110, 32'h0, 2'd1, 8'd2, 1'b1, 3'b010, 32'h0, 1'b0, "R8", 1'b0);
        run_txn(4'b0100, 32'hFFFF_0000, 2'd0, 8'd2, 1'b1, 3'b100, 32'h0, 1'b0, "R8", 1'b0);
        run_txn(4'b1110, 32'h0, 2'd2, 8'd5, 1'b0, 3'b010, 32'h0, 1'b0, "R8", 1'b0);
        run_txn(4'b0011, 32'h0, 2'd2, 8'd1, 1'b1, 3'b111, 32'h0, 1'b0, "R9", 1'b0);
        run_txn(4'b1000, 32'h5555_AAAA, 2'd0, 8'd4, 1'b0, 3'b000, 32'h0, 1'b0, "R9", 1'b0);
        tdiv = 1;
        run_txn(4'b0001, 32'hA5A5_0F0F, 2'd1, 8'd2, 1'b0, 3'b001, 32'h0, 1'b0, "R2", 1'b1);
        tdiv = 3;
        run_txn(4'b1110, 32'h0, 2'd0, 8'd1, 1'b0, 3'b001, 32'h8000_0000, 1'b0, "R4", 1'b0);

        repeat (50) @(negedge clk);
        check(!busy, "R2", "idle after mid-transfer start", {31'd0, busy}, 32'd0);
        check(sb_q.size() == 0, "R10", "all completions seen", sb_q.size(), 0);
        check(bad_clk == 0, "R3", "clock moved without strobe", bad_clk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule